// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block decides whether the receive side of a 10 Mb/s twisted-pair port has a live partner. It has three inputs that describe the line: a one-cycle strobe for each normal link pulse that an upstream detector accepts, a level that is high while received data is present, and a one-cycle millisecond tick. From these it keeps a link-pass or link-fail verdict. While the link has failed, it raises separate disable outputs for the transmit path, the receive path and the normal loopback path.

In the pass state, a loss window counts milliseconds. Each valid pulse restarts the window, and so does any receive activity. When the window runs out, the block goes through a one-cycle fail-reset state, which clears its pulse tally, and then waits in the fail state. Two events end the wait: received data, or enough well-spaced link pulses. A pulse that arrives too soon after the previous pulse is discarded. The block has two overrides. A test-enable input turns checking off. A forced-pass input pins the verdict at pass.

Top module: `lnk_integrity_mon`

## Requirements
- R1: While `lt_en_i` is low, the block moves to link-pass on the next clock edge and stays there, with all disables low, no matter how many ticks go by.
- R2: In link-pass, `link_pass_o` drops at the edge that samples the LOSS_MS-th `ms_tick_i` (default 100) since the window last restarted. The window restarts on a valid link pulse, on a cycle with `rx_active_i` high, and whenever the block is outside link-pass.
- R3: `tx_dis_o`, `rx_dis_o` and `lpbk_dis_o` are all high whenever `link_pass_o` is low, and all low whenever it is high.
- R4: A link pulse counts as valid only if at least MIN_GAP_MS ticks (default 3) have been sampled since the previous strobe, whether or not that earlier strobe was accepted. The first strobe after reset is valid.
- R5: In link-fail, the edge that samples the RECOV_PULSES-th valid pulse (default 2) returns the block to link-pass.
- R6: In link-fail, a cycle with `rx_active_i` high returns the block to link-pass at the next edge.
- R7: Entering link-fail clears the valid-pulse tally, so pulses counted in an earlier fail episode do not add to the next one.
- R8: While `force_pass_i` is high, the block is in link-pass from the next edge on, with all disables low. The loss window begins from zero after `force_pass_i` is released.
- R9: After reset, the block reports link-pass with all disables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lt_en_i | input | 1 | Link test enable; low turns checking off |
| force_pass_i | input | 1 | Holds the verdict at link-pass |
| lp_strobe_i | input | 1 | One-cycle strobe per detected link pulse |
| rx_active_i | input | 1 | High while received data is present |
| ms_tick_i | input | 1 | One-cycle strobe once per millisecond |
| link_pass_o | output | 1 | Link-pass verdict |
| tx_dis_o | output | 1 | Transmit disable |
| rx_dis_o | output | 1 | Receive disable |
| lpbk_dis_o | output | 1 | Normal loopback disable |

## Verification
The assertions check on every cycle that the three disables follow the verdict together, that both overrides produce link-pass one edge later, that a fall into link-fail only happens on a tick, and that every rise back to pass has a cause in the cycle before it (a strobe, receive activity or an override). Several behaviours can only be shown by the bench's scenarios: the exact tick on which the loss window expires, that a pulse restarts the window, that a strobe arriving too soon is discarded, that the tally is cleared between fail episodes, and that the window starts over after the forced-pass input is released.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  typedef enum logic [1:0] {
    LS_PASS     = 2'd0,
    LS_FAIL_RST = 2'd1,
    LS_FAIL     = 2'd2
  } lnk_state_e;
endpackage

// File: rtl/lnk_gap_filter.sv
module lnk_gap_filter #(
  parameter int MIN_GAP_MS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic strobe_i,
  output logic valid_o
);
  localparam int GW = $clog2(MIN_GAP_MS + 1);
  localparam logic [GW-1:0] GAP_SAT = GW'(MIN_GAP_MS);

  logic [GW-1:0] gap_q;

  // saturates at MIN_GAP_MS; reset value makes first strobe valid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       gap_q <= GAP_SAT;
    else if (strobe_i)                 gap_q <= '0;
    else if (tick_i && gap_q != GAP_SAT) gap_q <= gap_q + GW'(1);
  end

  assign valid_o = strobe_i && (gap_q == GAP_SAT);
endmodule

// File: rtl/lnk_loss_timer.sv
module lnk_loss_timer #(
  parameter int LOSS_MS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int LW = $clog2(LOSS_MS);
  localparam logic [LW-1:0] LAST = LW'(LOSS_MS - 1);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + LW'(1);
  end

  assign expire_o = run_i && !restart_i && tick_i && (cnt_q == LAST);
endmodule

// File: rtl/lnk_recover_cnt.sv
module lnk_recover_cnt #(
  parameter int NEED = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  output logic done_o
);
  localparam int CW = $clog2(NEED + 1);
  localparam logic [CW-1:0] LAST = CW'(NEED - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (inc_i && cnt_q != LAST) cnt_q <= cnt_q + CW'(1);
  end

  assign done_o = inc_i && !clear_i && (cnt_q == LAST);
endmodule

// File: rtl/lnk_integrity_mon.sv
module lnk_integrity_mon #(
  parameter int LOSS_MS      = 100,
  parameter int MIN_GAP_MS   = 3,
  parameter int RECOV_PULSES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lt_en_i,
  input  logic force_pass_i,
  input  logic lp_strobe_i,
  input  logic rx_active_i,
  input  logic ms_tick_i,
  output logic link_pass_o,
  output logic tx_dis_o,
  output logic rx_dis_o,
  output logic lpbk_dis_o
);
  import lnk_pkg::*;

  lnk_state_e state_q, state_d;
  logic pulse_ok, expire, rec_done, override, in_pass, in_fail;

  assign override = !lt_en_i || force_pass_i;
  assign in_pass  = (state_q == LS_PASS);
  assign in_fail  = (state_q == LS_FAIL);

  lnk_gap_filter #(.MIN_GAP_MS(MIN_GAP_MS)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (ms_tick_i),
    .strobe_i (lp_strobe_i),
    .valid_o  (pulse_ok)
  );

  lnk_loss_timer #(.LOSS_MS(LOSS_MS)) u_loss (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (in_pass && !override),
    .restart_i (pulse_ok || rx_active_i),
    .tick_i    (ms_tick_i),
    .expire_o  (expire)
  );

  lnk_recover_cnt #(.NEED(RECOV_PULSES)) u_rec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!in_fail || override),
    .inc_i   (pulse_ok && !rx_active_i),
    .done_o  (rec_done)
  );

  always_comb begin
    state_d = state_q;
    if (override) state_d = LS_PASS;
    else begin
      unique case (state_q)
        LS_PASS:     if (expire) state_d = LS_FAIL_RST;
        LS_FAIL_RST: state_d = rx_active_i ? LS_PASS : LS_FAIL;
        LS_FAIL:     if (rx_active_i || rec_done) state_d = LS_PASS;
        default:     state_d = LS_PASS;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LS_PASS;
    else         state_q <= state_d;
  end

  assign link_pass_o = in_pass;
  assign tx_dis_o    = !in_pass;
  assign rx_dis_o    = !in_pass;
  assign lpbk_dis_o  = !in_pass;
endmodule

// File: rtl/lnk_integrity_chk.sv
module lnk_integrity_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic lt_en_i,
  input logic force_pass_i,
  input logic lp_strobe_i,
  input logic rx_active_i,
  input logic ms_tick_i,
  input logic link_pass_o,
  input logic tx_dis_o,
  input logic rx_dis_o,
  input logic lpbk_dis_o
);
  AST_DIS_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_dis_o == !link_pass_o) && (rx_dis_o == tx_dis_o) && (lpbk_dis_o == tx_dis_o)); // R3

  AST_EN_OFF_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lt_en_i |=> link_pass_o); // R1

  AST_FORCE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_pass_i |=> (link_pass_o && !tx_dis_o)); // R8

  AST_FAIL_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_pass_o) |-> $past(ms_tick_i)); // R2

  AST_RECOVER_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_pass_o) |-> $past(lp_strobe_i || rx_active_i || force_pass_i || !lt_en_i)); // R5
endmodule

bind lnk_integrity_mon lnk_integrity_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lt_en_i      (lt_en_i),
  .force_pass_i (force_pass_i),
  .lp_strobe_i  (lp_strobe_i),
  .rx_active_i  (rx_active_i),
  .ms_tick_i    (ms_tick_i),
  .link_pass_o  (link_pass_o),
  .tx_dis_o     (tx_dis_o),
  .rx_dis_o     (rx_dis_o),
  .lpbk_dis_o   (lpbk_dis_o)
);

// File: tb/sim_lnk_integrity_mon.sv
module sim_lnk_integrity_mon;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic lt_en_i = 1'b1, force_pass_i = 1'b0;
  logic lp_strobe_i = 1'b0, rx_active_i = 1'b0, ms_tick_i = 1'b0;
  logic link_pass_o, tx_dis_o, rx_dis_o, lpbk_dis_o;
  logic en_q = 1'b1, fp_q = 1'b0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { logic exp; string tag; } exp_t;
  exp_t sb[$];

  always #10 clk_i = ~clk_i;

  lnk_integrity_mon u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .lt_en_i(lt_en_i), .force_pass_i(force_pass_i),
    .lp_strobe_i(lp_strobe_i), .rx_active_i(rx_active_i), .ms_tick_i(ms_tick_i),
    .link_pass_o(link_pass_o), .tx_dis_o(tx_dis_o), .rx_dis_o(rx_dis_o),
    .lpbk_dis_o(lpbk_dis_o)
  );

  // driver: apply one cycle of stimulus, queue the result expected after the edge
  task automatic cyc(input logic t, input logic p, input logic r,
                     input bit chk, input logic exp, input string tag);
    exp_t it;
    @(negedge clk_i);
    lt_en_i = en_q; force_pass_i = fp_q;
    ms_tick_i = t; lp_strobe_i = p; rx_active_i = r;
    if (chk) begin it.exp = exp; it.tag = tag; sb.push_back(it); end
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "");
  endtask

  // monitor: compare 5 ns after the edge
  initial forever begin
    exp_t it;
    @(posedge clk_i);
    #5;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      checks++;
      if (link_pass_o !== it.exp || tx_dis_o !== ~it.exp ||
          rx_dis_o !== ~it.exp || lpbk_dis_o !== ~it.exp) begin
        errors++;
        $display("FAIL %s: pass=%0b dis=%0b%0b%0b expected pass=%0b dis=%0b%0b%0b",
                 it.tag, link_pass_o, tx_dis_o, rx_dis_o, lpbk_dis_o,
                 it.exp, ~it.exp, ~it.exp, ~it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cyc(0, 0, 0, 1, 1, "R9");                    // reset state
    // R2: loss on the 100th tick
    run_ticks(98);
    cyc(1, 0, 0, 1, 1, "R2");
    cyc(1, 0, 0, 1, 0, "R2");
    cyc(0, 0, 0, 1, 0, "R3");
    // R4/R5: pulse recovery with a rejected early pulse
    cyc(0, 1, 0, 1, 0, "R5");
    cyc(0, 1, 0, 1, 0, "R4");
    run_ticks(3);
    cyc(0, 1, 0, 1, 1, "R5");
    // R2: pulse restarts window
    run_ticks(90);
    cyc(0, 1, 0, 1, 1, "R2");
    run_ticks(99);
    cyc(0, 0, 0, 1, 1, "R2");
    cyc(1, 0, 0, 1, 0, "R2");
    cyc(0, 0, 0, 1, 0, "R3");
    // R6: data recovers
    cyc(0, 0, 1, 1, 1, "R6");
    // R7: tally cleared between episodes
    run_ticks(100);
    cyc(0, 0, 0, 1, 0, "R7");
    cyc(0, 1, 0, 1, 0, "R7");
    cyc(0, 0, 1, 1, 1, "R6");
    run_ticks(100);
    cyc(0, 0, 0, 1, 0, "R7");
    cyc(0, 1, 0, 1, 0, "R7");
    // R8: forced pass
    fp_q = 1'b1;
    cyc(0, 0, 0, 1, 1, "R8");
    run_ticks(200);
    cyc(1, 0, 0, 1, 1, "R8");
    fp_q = 1'b0;
    run_ticks(98);
    cyc(1, 0, 0, 1, 1, "R8");
    cyc(1, 0, 0, 1, 0, "R8");
    // R1: checking disabled
    en_q = 1'b0;
    cyc(0, 0, 0, 1, 1, "R1");
    run_ticks(200);
    cyc(1, 0, 0, 1, 1, "R1");
    cyc(0, 0, 0, 0, 0, "");
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule